// File: doc/BRIEF.md
# I2C Bus Stuck-Data Recovery Sequencer

This block frees an I2C bus whose data line is being held low by a target that lost track of the controller, usually because the controller was reset in the middle of an acknowledge or a read bit. When it is triggered, the sequencer first looks at the data line. If the line is already high, the bus is free: the sequencer reports success at once and leaves the clock line alone. If the data line is low, the sequencer toggles the clock line through a fixed number of pulses. This lets the stalled target shift out whatever bit it was holding and then let go of the line.

The sequencer only ever pulls a line low or releases it, which matches open-drain wiring with external pull-ups. The data line is never driven and only the clock line moves. Each pulse has a released phase and a driven-low phase of equal length. That length is taken from a half-period count captured when the sequence starts. After the last pulse the clock line is left released and the data line is sampled once more. If the data line is still low, an error is raised. A controller normally runs this block after its own reset, before it issues a STOP and starts normal traffic.

Top module: `bus_unstick`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0, and scl_drive_low_o and sda_drive_low_o are 0 (both lines released).
- R2: A start accepted while sda_i reads 1 ends with one done_o pulse, err_o = 0 and no cycle with scl_drive_low_o = 1.
- R3: A start accepted while sda_i reads 0 produces exactly PULSE_COUNT (default 9) low phases on scl_drive_low_o. Each low phase is preceded by a released phase.
- R4: Every low phase, and every released phase between two low phases, lasts H cycles. H is half_period_i captured in the start cycle. Changes to half_period_i during a sequence have no effect.
- R5: After the last low phase, SCL is released and sda_i is sampled once more. err_o is 1 with done_o if sda_i is still 0, and 0 otherwise. err_o then holds its value until the next accepted start clears it.
- R6: sda_drive_low_o stays 0 at all times.
- R7: busy_o is 1 from the cycle after an accepted start through the cycle in which done_o is 1. done_o is high for exactly one cycle, and busy_o is 0 on the next cycle.
- R8: start_i while busy_o is 1 is ignored. The running sequence keeps its pulse count, and no new sequence follows it.
- R9: scl_drive_low_o is 0 whenever busy_o is 0, and it is 0 in the done_o cycle.
- R10: A captured half_period_i of 0 is treated as 1, so each phase lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only when idle |
| half_period_i | input | CNT_W | Clock cycles per SCL phase, captured at start |
| scl_drive_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it (always 0) |
| sda_i | input | 1 | Sampled SDA line level |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | SDA still low after the pulse train |

## Verification
The bench models a target that holds SDA low until it has seen a chosen number of SCL falling edges. Holding for zero edges separates the free-bus shortcut from the pulse path. Holding for one through nine edges shows that the full pulse train always runs and ends in success. Holding for ten or more edges is the only case that must end in an error. Sweeping the half-period (including 0), changing it during a run and sending extra start strobes mid-run distinguish a captured phase length from a live one, and an ignored strobe from a restart.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;

   typedef enum logic [2:0] {
      US_IDLE   = 3'd0,
      US_CHECK  = 3'd1,
      US_HIGH   = 3'd2,
      US_LOW    = 3'd3,
      US_SETTLE = 3'd4,
      US_DONE   = 3'd5
   } us_state_t;

endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("unstick_sync: STAGES must be >= 0");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES:0] r;
         assign r[0] = d;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r[i+1] <= 1'b1;
               else        r[i+1] <= r[i];
            end
         end
         assign q = r[STAGES];
      end
   endgenerate

endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/unstick_pulse_cnt.sv
module unstick_pulse_cnt #(
   parameter int N = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);

   localparam int PCW = (N < 2) ? 1 : $clog2(N);
   localparam logic [PCW-1:0] LAST_IDX = PCW'(N - 1);

   logic [PCW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign last = (cnt_q == LAST_IDX);

endmodule

// File: rtl/bus_unstick.sv
module bus_unstick
   import bus_unstick_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PULSE_COUNT = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] half_period_i,
   output logic             scl_drive_low_o,
   output logic             sda_drive_low_o,
   input  logic             sda_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);

   localparam int TW = CNT_W + 1;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("bus_unstick: CNT_W must be >= 1");
      end
      if (PULSE_COUNT < 1) begin : g_bad_n
         $error("bus_unstick: PULSE_COUNT must be >= 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_s
         $error("bus_unstick: SYNC_STAGES must be 0..4");
      end
   endgenerate

   us_state_t        st_q, st_n;
   logic [CNT_W-1:0] hp_q;
   logic             err_q, err_n;
   logic             scl_low_q;
   logic             sda_s;
   logic             tmr_ld, tmr_zero;
   logic [TW-1:0]    tmr_val;
   logic             cnt_clr, cnt_inc, cnt_last;
   logic             hp_ld;
   logic [TW-1:0]    hp_m1, settle_val;

   unstick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sda_i),
      .q     (sda_s)
   );

   unstick_timer #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_ld),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   unstick_pulse_cnt #(.N(PULSE_COUNT)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .last  (cnt_last)
   );

   assign hp_m1      = TW'(hp_q) - 1'b1;
   assign settle_val = hp_m1 + TW'(SYNC_STAGES);

   always_comb begin
      st_n    = st_q;
      tmr_ld  = 1'b0;
      tmr_val = '0;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      hp_ld   = 1'b0;
      err_n   = err_q;
      unique case (st_q)
         US_IDLE: begin
            if (start_i) begin
               st_n    = US_CHECK;
               tmr_ld  = 1'b1;
               tmr_val = TW'(SYNC_STAGES);
               cnt_clr = 1'b1;
               hp_ld   = 1'b1;
               err_n   = 1'b0;
            end
         end
         US_CHECK: begin
            if (tmr_zero) begin
               if (sda_s) begin
                  st_n = US_DONE;
               end else begin
                  st_n    = US_HIGH;
                  tmr_ld  = 1'b1;
                  tmr_val = hp_m1;
               end
            end
         end
         US_HIGH: begin
            if (tmr_zero) begin
               st_n    = US_LOW;
               tmr_ld  = 1'b1;
               tmr_val = hp_m1;
            end
         end
         US_LOW: begin
            if (tmr_zero) begin
               cnt_inc = 1'b1;
               tmr_ld  = 1'b1;
               if (cnt_last) begin
                  st_n    = US_SETTLE;
                  tmr_val = settle_val;
               end else begin
                  st_n    = US_HIGH;
                  tmr_val = hp_m1;
               end
            end
         end
         US_SETTLE: begin
            if (tmr_zero) begin
               st_n  = US_DONE;
               err_n = ~sda_s;
            end
         end
         US_DONE: begin
            st_n = US_IDLE;
         end
         default: begin
            st_n = US_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= US_IDLE;
         hp_q      <= CNT_W'(1);
         err_q     <= 1'b0;
         scl_low_q <= 1'b0;
      end else begin
         st_q      <= st_n;
         err_q     <= err_n;
         scl_low_q <= (st_n == US_LOW);
         if (hp_ld) hp_q <= (half_period_i == '0) ? CNT_W'(1) : half_period_i;
      end
   end

   assign scl_drive_low_o = scl_low_q;
   assign sda_drive_low_o = 1'b0;
   assign busy_o          = (st_q != US_IDLE);
   assign done_o          = (st_q == US_DONE);
   assign err_o           = err_q;

endmodule

// File: rtl/bus_unstick_chk.sv
module bus_unstick_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic scl_drive_low_o,
   input logic busy_o,
   input logic done_o,
   input logic err_o
);

   // R7
   done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   // R9
   scl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !scl_drive_low_o);

   // R9
   done_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !scl_drive_low_o);

   // R8
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R5
   err_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err_o) |-> (done_o || $past(start_i && !busy_o)));

endmodule

bind bus_unstick bus_unstick_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .start_i         (start_i),
   .scl_drive_low_o (scl_drive_low_o),
   .busy_o          (busy_o),
   .done_o          (done_o),
   .err_o           (err_o)
);

// File: tb/sim_bus_unstick.sv
module sim_bus_unstick;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int PULSES     = 9;
   localparam int LIMIT      = 2000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [CNT_W-1:0] half = '0;
   logic             scl_low, sda_drv, sda_line, busy, done, err;

   int n_tests = 0;
   int n_fail  = 0;

   int hold_target = 0;
   int exp_hp      = 1;
   int falls = 0, low_run = 0, high_run = 0, bad_low = 0, bad_gap = 0;
   bit sda_seen = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = (falls >= hold_target);

   bus_unstick #(.CNT_W(CNT_W), .PULSE_COUNT(PULSES), .SYNC_STAGES(2)) u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_i         (start),
      .half_period_i   (half),
      .scl_drive_low_o (scl_low),
      .sda_drive_low_o (sda_drv),
      .sda_i           (sda_line),
      .busy_o          (busy),
      .done_o          (done),
      .err_o           (err)
   );

   // target and phase monitor
   always @(negedge clk) begin
      if (sda_drv) sda_seen = 1'b1;
      if (!busy) begin
         falls = 0; low_run = 0; high_run = 0; bad_low = 0; bad_gap = 0;
      end else if (scl_low) begin
         if (low_run == 0) begin
            falls++;
            if (falls > 1 && high_run != exp_hp) bad_gap++;
         end
         low_run++;
         high_run = 0;
      end else begin
         if (low_run != 0 && low_run != exp_hp) bad_low++;
         low_run = 0;
         high_run++;
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic run_case(input int k, input int h, input bit mid_start, input int h_alt);
      int cyc;
      int exp_falls;
      bit exp_err;
      exp_hp    = (h == 0) ? 1 : h;
      exp_falls = (k == 0) ? 0 : PULSES;
      exp_err   = (k > PULSES);
      hold_target = k;
      half  = CNT_W'(h);
      start = 1'b1;
      step();
      start = 1'b0;
      if (mid_start) half = CNT_W'(h_alt);
      chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
      chk(err == 1'b0, "R5 err cleared by start", int'(err), 0);
      cyc = 0;
      while (!done && cyc < LIMIT) begin
         if (mid_start && (cyc == 4 || cyc == 20)) start = 1'b1;
         step();
         start = 1'b0;
         cyc++;
      end
      start = 1'b0;
      chk(cyc < LIMIT, "R7 done reached (watchdog)", cyc, LIMIT);
      chk(busy == 1'b1, "R7 busy in done cycle", int'(busy), 1);
      chk(err == exp_err, (k == 0) ? "R2 err free bus" : "R5 err after pulses", int'(err), int'(exp_err));
      chk(falls == exp_falls, (k == 0) ? "R2 no pulses" : (mid_start ? "R8 pulse count" : "R3 pulse count"),
          falls, exp_falls);
      chk(bad_low == 0, (h == 0) ? "R10 low phase length" : "R4 low phase length", bad_low, 0);
      chk(bad_gap == 0, (h == 0) ? "R10 high phase length" : "R4 high phase length", bad_gap, 0);
      chk(scl_low == 1'b0, "R9 scl released at done", int'(scl_low), 0);
      step();
      chk(done == 1'b0 && busy == 1'b0, "R7 done one cycle", int'(done) + int'(busy), 0);
      chk(scl_low == 1'b0, "R9 scl released idle", int'(scl_low), 0);
      repeat (5) step();
      chk(err == exp_err, "R5 err held", int'(err), int'(exp_err));
      chk(busy == 1'b0, "R8 no restart after stray start", int'(busy), 0);
      chk(sda_seen == 1'b0, "R6 sda never driven", int'(sda_seen), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) step();
      chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 status at reset",
          int'(busy) + int'(done) + int'(err), 0);
      chk(scl_low == 1'b0 && sda_drv == 1'b0, "R1 lines released at reset",
          int'(scl_low) + int'(sda_drv), 0);
      rst_n = 1'b1;
      repeat (2) step();
      chk(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

      run_case(0, 3, 1'b0, 0);
      run_case(1, 2, 1'b0, 0);
      run_case(PULSES, 2, 1'b0, 0);
      run_case(PULSES + 1, 2, 1'b0, 0);
      run_case(0, 2, 1'b0, 0);
      run_case(12, 0, 1'b0, 0);
      run_case(5, 4, 1'b1, 7);
      run_case(PULSES + 3, 1, 1'b1, 0);

      for (int i = 0; i < 20; i++) begin
         int k, h;
         k = int'($urandom_range(0, 12));
         h = int'($urandom_range(0, 6));
         run_case(k, h, (i % 3) == 0 && k != 0, int'($urandom_range(0, 6)));
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule